// File: doc/BRIEF.md
# Hypervisor Coprocessor Trap Control

This block keeps the hypervisor's trap-control word for coprocessor-style functions and answers, for every access request, whether that access has to be diverted to the hypervisor level (level 2). It also reports which syndrome class the exception should carry. Requests can come from floating-point/SIMD code, scalable-vector code, trace register accesses, activity-monitor register accesses, or accesses to the lower-level access-control register. Each request also carries its encoding form: a 64-bit system register access, a 32-bit single-register coprocessor transfer, or a 32-bit dual-register coprocessor transfer.

The word has two bit layouts. The host-extension mode input chooses which one applies to writes and reads. In the wide-enable layout, the FP and vector controls are 2-bit enable fields. In the compact layout they are single trap bits, and several bits are held at one. The host-trap-general mode input changes what the 2-bit enable code 01 means, and it turns off the access-control trap. The trap, undefined and syndrome outputs are combinational. They are valid in the same cycle as the request strobe, and a write is seen by requests from the next cycle on.

Top module: `cptr_trap_ctrl`

## Requirements
- R1: Bits [63:32] of the read value are always zero. After reset the read value is 0x0000_0000_0033_0000 when host-extension is 1 and 0x0000_0000_0000_32FF when host-extension is 0, and no request traps.
- R2: With host-extension 1, a write stores the access-control trap from bit 31, the activity-monitor trap from bit 30, the trace trap from bit 28, the FP enable from [21:20] and the vector enable from [17:16]. All other bits read as zero, so writing all ones reads back 0x0000_0000_D033_0000.
- R3: With host-extension 0, a write stores bits 31, 30 and 20 (trace trap), bit 10 (FP trap) and bit 8 (vector trap). Bits [13:12], bit 9 and [7:0] read as one, so writing all ones reads back 0x0000_0000_C010_37FF. A set trap bit is held as enable 00 and a clear trap bit as enable 11.
- R4: For a 2-bit enable, 00 and 10 trap requests at levels 0, 1 and 2, and 11 traps nothing. 01 traps nothing when host-trap-general is 0, and traps only level 0 when host-trap-general is 1.
- R5: A vector request (class 1) that the vector control traps reports syndrome 0x19, even if the FP control also traps. If only the FP control traps, it reports 0x07. An FP request (class 0) is not affected by the vector control.
- R6: The access-control trap (class 4) fires only for level-1 requests, and only when host-trap-general is 0.
- R7: The syndrome classes are as follows. Form 0 (64-bit system access) gives 0x18 for trace, activity-monitor and access-control requests. Form 1 gives 0x03 for activity-monitor and access-control requests and 0x05 for trace requests. Form 2 gives 0x04 for activity-monitor requests and 0x0C for trace requests. FP traps give 0x07. Syndrome is 0 whenever trap is 0.
- R8: No trap is raised while the hypervisor-enabled input is 0.
- R9: A level-0 trace request (class 2), and a level-0 FP request that targets an FP identification/control register, raise undefined. In those cases trap is 0.
- R10: Level-3 requests never trap. The activity-monitor trap (class 3) fires only at levels 0 and 1. Nothing is asserted when the request strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 64 | Write data, decoded in the current layout |
| host_ext | input | 1 | Layout select: 1 wide-enable, 0 compact |
| host_general | input | 1 | Host-trap-general mode |
| hyp_en | input | 1 | Hypervisor level enabled in current security state |
| rd_data | output | 64 | Control word as seen in the current layout |
| req_valid | input | 1 | Access request strobe |
| req_level | input | 2 | Privilege level of the request (0..3) |
| req_class | input | 3 | 0 FP/SIMD, 1 vector, 2 trace, 3 activity monitor, 4 access control |
| req_form | input | 2 | 0 system 64-bit, 1 coprocessor single, 2 coprocessor dual |
| req_id_reg | input | 1 | FP request targets an identification/control register |
| trap | output | 1 | Access traps to level 2 |
| undef | output | 1 | Access is undefined |
| syndrome | output | 6 | Syndrome class of the trap |

## Verification
Several cases cannot be reached with a single write. One is a vector request where both the vector and FP controls are set to trap. Another is the 01 enable code under each setting of host-trap-general. A third is a stored value written in one layout and then read or decoded in the other. The bench writes the word under one host-extension setting and changes the mode inputs only at request time. It then sweeps the level, class and form at that stored state, so the priority and undefined-over-trap cases all see the same configuration.

// File: rtl/cptr_pkg.sv
package cptr_pkg;
    localparam int REG_W  = 64;
    localparam int HALF_W = REG_W / 2;
    localparam int SYN_W  = 6;
    localparam int LVL_W  = 2;
    localparam int CLS_W  = 3;
    localparam int FORM_W = 2;

    typedef enum logic [CLS_W-1:0] {
        CLS_FP    = 3'd0,
        CLS_VEC   = 3'd1,
        CLS_TRACE = 3'd2,
        CLS_AMON  = 3'd3,
        CLS_ACC   = 3'd4
    } cls_e;

    typedef enum logic [FORM_W-1:0] {
        FORM_SYS64  = 2'd0,
        FORM_CP_ONE = 2'd1,
        FORM_CP_TWO = 2'd2
    } form_e;

    typedef struct packed {
        logic       acc;
        logic       amon;
        logic       trace;
        logic [1:0] fp_en;
        logic [1:0] vec_en;
    } ctl_t;

    localparam logic [1:0] EN_OPEN = 2'b11;
    localparam logic [1:0] EN_SHUT = 2'b00;

    localparam logic [SYN_W-1:0] SYN_SYS64    = 6'h18;
    localparam logic [SYN_W-1:0] SYN_CP_ONE   = 6'h03;
    localparam logic [SYN_W-1:0] SYN_CP_TWO   = 6'h04;
    localparam logic [SYN_W-1:0] SYN_FP       = 6'h07;
    localparam logic [SYN_W-1:0] SYN_TRC_ONE  = 6'h05;
    localparam logic [SYN_W-1:0] SYN_TRC_TWO  = 6'h0C;
    localparam logic [SYN_W-1:0] SYN_VEC      = 6'h19;

    localparam logic [HALF_W-1:0] NARROW_ONES = 32'h0000_32FF;

    localparam ctl_t CTL_RESET = '{acc: 1'b0, amon: 1'b0, trace: 1'b0,
                                   fp_en: EN_OPEN, vec_en: EN_OPEN};

    function automatic logic en_traps(input logic [1:0] en, input logic general,
                                      input logic [LVL_W-1:0] lvl);
        logic hit;
        if (lvl == 2'd3 || en == EN_OPEN) hit = 1'b0;
        else if (en == 2'b01)             hit = general && (lvl == 2'd0);
        else                              hit = 1'b1;
        return hit;
    endfunction

    function automatic logic [1:0] bit_to_en(input logic b);
        return b ? EN_SHUT : EN_OPEN;
    endfunction

    function automatic logic en_to_bit(input logic [1:0] en);
        return en != EN_OPEN;
    endfunction
endpackage

// File: rtl/cptr_store.sv
module cptr_store
    import cptr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             host_ext,
    output ctl_t             ctl,
    output logic [REG_W-1:0] view
);
    ctl_t ctl_q;
    ctl_t wide_dec;
    ctl_t narrow_dec;
    logic [HALF_W-1:0] wide_view;
    logic [HALF_W-1:0] narrow_view;

    always_comb begin
        wide_dec.acc    = wr_data[31];
        wide_dec.amon   = wr_data[30];
        wide_dec.trace  = wr_data[28];
        wide_dec.fp_en  = wr_data[21:20];
        wide_dec.vec_en = wr_data[17:16];

        narrow_dec.acc    = wr_data[31];
        narrow_dec.amon   = wr_data[30];
        narrow_dec.trace  = wr_data[20];
        narrow_dec.fp_en  = bit_to_en(wr_data[10]);
        narrow_dec.vec_en = bit_to_en(wr_data[8]);
    end

    always_ff @(posedge clk) begin
        if (rst)         ctl_q <= CTL_RESET;
        else if (wr_en)  ctl_q <= host_ext ? wide_dec : narrow_dec;
    end

    always_comb begin
        wide_view        = '0;
        wide_view[31]    = ctl_q.acc;
        wide_view[30]    = ctl_q.amon;
        wide_view[28]    = ctl_q.trace;
        wide_view[21:20] = ctl_q.fp_en;
        wide_view[17:16] = ctl_q.vec_en;

        narrow_view      = NARROW_ONES;
        narrow_view[31]  = ctl_q.acc;
        narrow_view[30]  = ctl_q.amon;
        narrow_view[20]  = ctl_q.trace;
        narrow_view[10]  = en_to_bit(ctl_q.fp_en);
        narrow_view[8]   = en_to_bit(ctl_q.vec_en);
    end

    assign ctl  = ctl_q;
    assign view = {{(REG_W-HALF_W){1'b0}}, host_ext ? wide_view : narrow_view};
endmodule

// File: rtl/cptr_trap_eval.sv
module cptr_trap_eval
    import cptr_pkg::*;
(
    input  ctl_t              ctl,
    input  logic              host_ext,
    input  logic              host_general,
    input  logic              hyp_en,
    input  logic              req_valid,
    input  logic [LVL_W-1:0]  req_level,
    input  logic [CLS_W-1:0]  req_class,
    input  logic [FORM_W-1:0] req_form,
    input  logic              req_id_reg,
    output logic              trap,
    output logic              undef,
    output logic [SYN_W-1:0]  syndrome
);
    logic [1:0] fp_eff, vec_eff;
    logic fp_hit, vec_hit, trc_hit, amon_hit, acc_hit;
    logic is_undef, raw_trap;
    logic [SYN_W-1:0] raw_syn;

    always_comb begin
        fp_eff  = host_ext ? ctl.fp_en  : bit_to_en(en_to_bit(ctl.fp_en));
        vec_eff = host_ext ? ctl.vec_en : bit_to_en(en_to_bit(ctl.vec_en));
        fp_hit   = en_traps(fp_eff, host_general, req_level);
        vec_hit  = en_traps(vec_eff, host_general, req_level);
        trc_hit  = ctl.trace && (req_level != 2'd3);
        amon_hit = ctl.amon && (req_level <= 2'd1);
        acc_hit  = ctl.acc && (req_level == 2'd1) && !host_general;

        is_undef = req_valid && (req_level == 2'd0) &&
                   ((req_class == CLS_TRACE) || ((req_class == CLS_FP) && req_id_reg));

        raw_trap = 1'b0;
        raw_syn  = '0;
        case (req_class)
            CLS_FP: begin
                raw_trap = fp_hit;
                raw_syn  = SYN_FP;
            end
            CLS_VEC: begin
                raw_trap = vec_hit || fp_hit;
                raw_syn  = vec_hit ? SYN_VEC : SYN_FP;
            end
            CLS_TRACE: begin
                raw_trap = trc_hit && (req_form != 2'd3);
                case (req_form)
                    FORM_CP_ONE: raw_syn = SYN_TRC_ONE;
                    FORM_CP_TWO: raw_syn = SYN_TRC_TWO;
                    default:     raw_syn = SYN_SYS64;
                endcase
            end
            CLS_AMON: begin
                raw_trap = amon_hit && (req_form != 2'd3);
                case (req_form)
                    FORM_CP_ONE: raw_syn = SYN_CP_ONE;
                    FORM_CP_TWO: raw_syn = SYN_CP_TWO;
                    default:     raw_syn = SYN_SYS64;
                endcase
            end
            CLS_ACC: begin
                raw_trap = acc_hit && (req_form != FORM_CP_TWO) && (req_form != 2'd3);
                raw_syn  = (req_form == FORM_CP_ONE) ? SYN_CP_ONE : SYN_SYS64;
            end
            default: begin
                raw_trap = 1'b0;
                raw_syn  = '0;
            end
        endcase

        undef    = is_undef;
        trap     = req_valid && hyp_en && !is_undef && raw_trap;
        syndrome = trap ? raw_syn : '0;
    end
endmodule

// File: rtl/cptr_trap_ctrl.sv
module cptr_trap_ctrl
    import cptr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              host_ext,
    input  logic              host_general,
    input  logic              hyp_en,
    output logic [REG_W-1:0]  rd_data,
    input  logic              req_valid,
    input  logic [LVL_W-1:0]  req_level,
    input  logic [CLS_W-1:0]  req_class,
    input  logic [FORM_W-1:0] req_form,
    input  logic              req_id_reg,
    output logic              trap,
    output logic              undef,
    output logic [SYN_W-1:0]  syndrome
);
    ctl_t ctl;

    cptr_store u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .host_ext (host_ext),
        .ctl      (ctl),
        .view     (rd_data)
    );

    cptr_trap_eval u_eval (
        .ctl          (ctl),
        .host_ext     (host_ext),
        .host_general (host_general),
        .hyp_en       (hyp_en),
        .req_valid    (req_valid),
        .req_level    (req_level),
        .req_class    (req_class),
        .req_form     (req_form),
        .req_id_reg   (req_id_reg),
        .trap         (trap),
        .undef        (undef),
        .syndrome     (syndrome)
    );
endmodule

// File: rtl/cptr_trap_checker.sv
module cptr_trap_checker
    import cptr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [REG_W-1:0]  wr_data,
    input logic              host_ext,
    input logic              host_general,
    input logic              hyp_en,
    input logic [REG_W-1:0]  rd_data,
    input logic              req_valid,
    input logic [LVL_W-1:0]  req_level,
    input logic [CLS_W-1:0]  req_class,
    input logic              trap,
    input logic              undef,
    input logic [SYN_W-1:0]  syndrome
);
    p_upper_zero_r1: assert property (@(posedge clk) disable iff (rst)
        rd_data[REG_W-1:HALF_W] == '0);

    p_wide_store_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && host_ext) |=> (!host_ext || (rd_data[31:30] == $past(wr_data[31:30]))));

    p_narrow_ones_r3: assert property (@(posedge clk) disable iff (rst)
        !host_ext |-> ((rd_data[HALF_W-1:0] & NARROW_ONES) == NARROW_ONES));

    p_acc_scope_r6: assert property (@(posedge clk) disable iff (rst)
        (trap && req_class == CLS_ACC) |-> (req_level == 2'd1 && !host_general));

    p_syn_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !trap |-> syndrome == '0);

    p_hyp_off_r8: assert property (@(posedge clk) disable iff (rst)
        !hyp_en |-> !trap);

    p_undef_wins_r9: assert property (@(posedge clk) disable iff (rst)
        undef |-> !trap);

    p_level3_r10: assert property (@(posedge clk) disable iff (rst)
        (req_level == 2'd3 || !req_valid) |-> !trap);
endmodule

bind cptr_trap_ctrl cptr_trap_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .host_ext     (host_ext),
    .host_general (host_general),
    .hyp_en       (hyp_en),
    .rd_data      (rd_data),
    .req_valid    (req_valid),
    .req_level    (req_level),
    .req_class    (req_class),
    .trap         (trap),
    .undef        (undef),
    .syndrome     (syndrome)
);

// File: tb/cptr_trap_ctrl_bench.sv
module cptr_trap_ctrl_bench;
    import cptr_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic        host_ext = 1'b1;
    logic        host_general = 1'b0;
    logic        hyp_en = 1'b1;
    logic [63:0] rd_data;
    logic        req_valid = 1'b0;
    logic [1:0]  req_level = '0;
    logic [2:0]  req_class = '0;
    logic [1:0]  req_form = '0;
    logic        req_id_reg = 1'b0;
    logic        trap, undef;
    logic [5:0]  syndrome;

    int n_checks = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    cptr_trap_ctrl u_cptr_trap_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .host_ext(host_ext), .host_general(host_general), .hyp_en(hyp_en),
        .rd_data(rd_data), .req_valid(req_valid), .req_level(req_level),
        .req_class(req_class), .req_form(req_form), .req_id_reg(req_id_reg),
        .trap(trap), .undef(undef), .syndrome(syndrome)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic write_word(input logic ext, input logic [63:0] d);
        @(negedge clk);
        host_ext = ext; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic request(input logic [1:0] lvl, input logic [2:0] cls,
                           input logic [1:0] form, input logic idr);
        req_level = lvl; req_class = cls; req_form = form; req_id_reg = idr;
        req_valid = 1'b1;
        #1;
    endtask

    task automatic expect_req(input string tag, input logic [1:0] lvl, input logic [2:0] cls,
                              input logic [1:0] form, input logic idr,
                              input logic e_trap, input logic e_undef, input logic [5:0] e_syn);
        request(lvl, cls, form, idr);
        check({tag, " trap"}, 64'(trap), 64'(e_trap));
        check({tag, " undef"}, 64'(undef), 64'(e_undef));
        check({tag, " syndrome"}, 64'(syndrome), 64'(e_syn));
    endtask

    task automatic t_reset();
        host_ext = 1'b1; #1;
        check("R1 reset wide view", rd_data, 64'h0000_0000_0033_0000);
        host_ext = 1'b0; #1;
        check("R1 reset compact view", rd_data, 64'h0000_0000_0000_32FF);
        for (int lv = 1; lv < 3; lv++)
            for (int c = 0; c < 5; c++) begin
                request(2'(lv), 3'(c), 2'd0, 1'b0);
                check("R1 reset no trap", 64'(trap), 64'd0);
            end
        host_ext = 1'b1;
        expect_req("R1 reset L0 vector", 2'd0, 3'd1, 2'd0, 1'b0, 1'b0, 1'b0, 6'h00);
    endtask

    task automatic t_wide_rw();
        write_word(1'b1, '1);
        check("R2 wide all ones", rd_data, 64'h0000_0000_D033_0000);
        write_word(1'b1, 64'h0000_0000_1020_0000);
        check("R2 trace bit and fp 10", rd_data, 64'h0000_0000_1020_0000);
    endtask

    task automatic t_narrow_rw();
        write_word(1'b0, '1);
        check("R3 compact all ones", rd_data, 64'h0000_0000_C010_37FF);
        write_word(1'b0, 64'h0000_0000_0000_0400);
        check("R3 fp bit only", rd_data, 64'h0000_0000_0000_36FF);
        host_ext = 1'b1; #1;
        check("R3 fp bit seen as enable 00", rd_data, 64'h0000_0000_0003_0000);
        host_ext = 1'b0;
    endtask

    task automatic t_enable_codes();
        for (int g = 0; g < 2; g++)
            for (int code = 0; code < 4; code++) begin
                write_word(1'b1, 64'(((code & 3) << 20) | (3 << 16)));
                host_general = 1'(g);
                for (int lv = 0; lv < 4; lv++) begin
                    logic e;
                    if (lv == 3 || code == 3) e = 1'b0;
                    else if (code == 1)      e = (g == 1) && (lv == 0);
                    else                     e = 1'b1;
                    expect_req("R4 fp enable code", 2'(lv), 3'd0, 2'd0, 1'b0,
                               e, 1'b0, e ? 6'h07 : 6'h00);
                end
            end
        host_general = 1'b0;
    endtask

    task automatic t_vec_prio();
        write_word(1'b1, 64'h0000_0000_0000_0000);
        expect_req("R5 both trap", 2'd1, 3'd1, 2'd0, 1'b0, 1'b1, 1'b0, 6'h19);
        write_word(1'b1, 64'h0000_0000_0003_0000);
        expect_req("R5 fp only on vector", 2'd1, 3'd1, 2'd0, 1'b0, 1'b1, 1'b0, 6'h07);
        write_word(1'b1, 64'h0000_0000_0030_0000);
        expect_req("R5 vector only", 2'd2, 3'd1, 2'd0, 1'b0, 1'b1, 1'b0, 6'h19);
        expect_req("R5 fp request ignores vector", 2'd2, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 6'h00);
        write_word(1'b0, 64'h0000_0000_0000_0100);
        expect_req("R5 compact vector bit", 2'd1, 3'd1, 2'd0, 1'b0, 1'b1, 1'b0, 6'h19);
    endtask

    task automatic t_access_ctrl();
        write_word(1'b0, 64'h0000_0000_8000_0000);
        expect_req("R6 level1", 2'd1, 3'd4, 2'd0, 1'b0, 1'b1, 1'b0, 6'h18);
        expect_req("R6 level0", 2'd0, 3'd4, 2'd0, 1'b0, 1'b0, 1'b0, 6'h00);
        expect_req("R6 level2", 2'd2, 3'd4, 2'd0, 1'b0, 1'b0, 1'b0, 6'h00);
        host_general = 1'b1;
        expect_req("R6 general mode", 2'd1, 3'd4, 2'd0, 1'b0, 1'b0, 1'b0, 6'h00);
        host_general = 1'b0;
    endtask

    task automatic t_syndromes();
        write_word(1'b0, 64'h0000_0000_C010_0400);
        expect_req("R7 acc sys", 2'd1, 3'd4, 2'd0, 1'b0, 1'b1, 1'b0, 6'h18);
        expect_req("R7 acc cp", 2'd1, 3'd4, 2'd1, 1'b0, 1'b1, 1'b0, 6'h03);
        expect_req("R7 amon sys", 2'd1, 3'd3, 2'd0, 1'b0, 1'b1, 1'b0, 6'h18);
        expect_req("R7 amon cp", 2'd0, 3'd3, 2'd1, 1'b0, 1'b1, 1'b0, 6'h03);
        expect_req("R7 amon dual", 2'd1, 3'd3, 2'd2, 1'b0, 1'b1, 1'b0, 6'h04);
        expect_req("R7 trace sys", 2'd1, 3'd2, 2'd0, 1'b0, 1'b1, 1'b0, 6'h18);
        expect_req("R7 trace cp", 2'd2, 3'd2, 2'd1, 1'b0, 1'b1, 1'b0, 6'h05);
        expect_req("R7 trace dual", 2'd1, 3'd2, 2'd2, 1'b0, 1'b1, 1'b0, 6'h0C);
        expect_req("R7 fp", 2'd2, 3'd0, 2'd0, 1'b0, 1'b1, 1'b0, 6'h07);
        expect_req("R10 amon level2", 2'd2, 3'd3, 2'd0, 1'b0, 1'b0, 1'b0, 6'h00);
        expect_req("R10 trace level3", 2'd3, 3'd2, 2'd0, 1'b0, 1'b0, 1'b0, 6'h00);
        req_valid = 1'b0; #1;
        check("R10 no strobe trap", 64'(trap), 64'd0);
        check("R10 no strobe undef", 64'(undef), 64'd0);
    endtask

    task automatic t_hyp_off();
        write_word(1'b0, 64'h0000_0000_C010_0500);
        hyp_en = 1'b0;
        for (int c = 0; c < 5; c++) begin
            request(2'd1, 3'(c), 2'd0, 1'b0);
            check("R8 hyp off", 64'(trap), 64'd0);
        end
        hyp_en = 1'b1;
        expect_req("R8 hyp back on", 2'd1, 3'd0, 2'd0, 1'b0, 1'b1, 1'b0, 6'h07);
    endtask

    task automatic t_undef();
        write_word(1'b0, 64'h0000_0000_0010_0400);
        expect_req("R9 L0 trace", 2'd0, 3'd2, 2'd1, 1'b0, 1'b0, 1'b1, 6'h00);
        expect_req("R9 L0 fp id reg", 2'd0, 3'd0, 2'd0, 1'b1, 1'b0, 1'b1, 6'h00);
        expect_req("R9 L0 fp data", 2'd0, 3'd0, 2'd0, 1'b0, 1'b1, 1'b0, 6'h07);
        expect_req("R9 L1 fp id reg", 2'd1, 3'd0, 2'd0, 1'b1, 1'b1, 1'b0, 6'h07);
        req_valid = 1'b0; #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_wide_rw();
        t_narrow_rw();
        t_enable_codes();
        t_vec_prio();
        t_access_ctrl();
        t_syndromes();
        t_hyp_off();
        t_undef();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule